// File: doc/BRIEF.md
# Multicycle 16-bit Register Machine Core

A compact processor core built around eight 16-bit general-purpose registers and a 16-bit program counter. It talks to one word-addressed 16-bit memory through a single port made of an address, a write-data word, a read-data word and a write strobe. Instructions and data share this port. The memory is expected to return read data in the same cycle the address is presented.

Each instruction takes several clock cycles, sequenced by a five-state controller. First the instruction is fetched and the PC is incremented. Next the operands are read and the PC-relative target and any memory address are formed. Then the operation is carried out: an ALU result, an upper-immediate load, a jump, a branch, or a memory access with its writeback. Control transfers are relative to the incremented PC. Jump-and-link saves the return address in any register. Conditional branches compare one register with zero. An asynchronous active-low reset returns the core to address 0 with every register cleared, and its release is synchronised to the clock.

Top module: `mc16_core`

## Requirements
- R1: While `arst_n` is low, `mem_we` is 0 and `mem_addr` is 0. After release, execution starts by fetching address 0, and all eight registers read as zero until written.
- R2: A word whose bits[15:12] are 0000 is a register ALU op. It reads src1 from bits[11:9] and src2 from bits[8:6], and writes the register in bits[5:3], which may equal either source. The function in bits[2:0] is one of these: 001 gives 1 if src1 < src2 unsigned (else 0), 010 gives src1 - src2, 011 gives src1 + src2, 100 xor, 101 or, 110 and, 111 passes src2. All results are taken modulo 2^16.
- R3: A word with bit 15 set is an immediate ALU op. The function is in bits[14:12] with the same codes as R2. The register in bits[11:9] is both the first operand and the destination. The second operand is bits[8:0] sign-extended to 16 bits.
- R4: Function code 000 in either ALU form writes no register and only advances the PC.
- R5: Opcode 0001 loads the register in bits[11:9] with bits[7:0] shifted left by 8. The low byte of the register becomes zero.
- R6: Opcode 0010 (load) and opcode 0011 (store) address memory at the register in bits[8:6] plus bits[5:0] sign-extended. Load writes the read word to the register in bits[11:9]. Store writes that register's value to memory.
- R7: Opcode 0100 writes the address of the next instruction to the register in bits[11:9]. It then continues at that address plus bits[8:0] sign-extended, in either direction.
- R8: Opcode 0101 continues at the address held in the register in bits[11:9].
- R9: Opcode 0110 branches when the register in bits[11:9] is nonzero, and opcode 0111 branches when it is zero. The branch target is computed as in R7. When the condition fails, execution continues with the next word.
- R10: Loads take 4 cycles. Every other instruction takes 3 cycles. Each store raises `mem_we` in exactly one cycle, and `mem_we` is raised at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Word address: the PC during fetch, the data address during a memory access |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Write strobe, high for one cycle per store |
| mem_rdata | input | 16 | Read data, valid in the same cycle as `mem_addr` |

## Verification
The bench builds the core with its default two-stage reset synchroniser. With the fixed 16-bit word and eight registers, all eight function codes of both ALU forms can be swept. Each code is applied to operand pairs chosen to hit carry, borrow, unsigned-compare and sign-extension edges. Hand-encoded programs then cover forward and backward links, a register jump, all four taken and not-taken branch cases, and loads and stores with negative offsets. The cycle gaps between store strobes are measured to confirm the per-instruction cycle counts.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

  localparam int unsigned WORD_W  = 16;
  localparam int unsigned REG_CNT = 8;
  localparam int unsigned RIDX_W  = $clog2(REG_CNT);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [RIDX_W-1:0] ridx_t;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_WB     = 3'd4
  } state_e;

  typedef enum logic [2:0] {
    OP_RALU = 3'd0,
    OP_LUI  = 3'd1,
    OP_LW   = 3'd2,
    OP_SW   = 3'd3,
    OP_JL   = 3'd4,
    OP_JR   = 3'd5,
    OP_BNZ  = 3'd6,
    OP_BZ   = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    FN_NONE = 3'd0,
    FN_LTU  = 3'd1,
    FN_SUB  = 3'd2,
    FN_ADD  = 3'd3,
    FN_XOR  = 3'd4,
    FN_OR   = 3'd5,
    FN_AND  = 3'd6,
    FN_PASS = 3'd7
  } fn_e;

  typedef enum logic [1:0] {WB_ALU, WB_UPPER, WB_LINK, WB_MEM} wsel_e;
  typedef enum logic [1:0] {PC_HOLD, PC_INC, PC_TARGET, PC_REG} pcsel_e;

  typedef struct packed {
    logic  imm_form;
    op_e   op;
    fn_e   fn;
    ridx_t ra;
    ridx_t rb;
    ridx_t rd;
  } dec_t;

  function automatic word_t sext9(logic [8:0] v);
    return {{(WORD_W-9){v[8]}}, v};
  endfunction

  function automatic word_t sext6(logic [5:0] v);
    return {{(WORD_W-6){v[5]}}, v};
  endfunction

  function automatic word_t upper(logic [7:0] v);
    return {v, {(WORD_W-8){1'b0}}};
  endfunction

  function automatic dec_t decode(word_t w);
    dec_t d;
    d.imm_form = w[15];
    d.op       = op_e'(w[14:12]);
    d.fn       = w[15] ? fn_e'(w[14:12]) : fn_e'(w[2:0]);
    d.ra       = w[11:9];
    d.rb       = w[8:6];
    d.rd       = (!w[15] && (w[14:12] == 3'd0)) ? w[5:3] : w[11:9];
    return d;
  endfunction

endpackage

// File: rtl/mc16_rst_sync.sv
module mc16_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter  int unsigned W  = 16,
  parameter  int unsigned N  = 8,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);

  logic [N-1:0][W-1:0] cells;

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic [W-1:0] cell_q;
    logic         cell_en;

    assign cell_en = we && (waddr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= '0;
      end else if (cell_en) begin
        cell_q <= wdata;
      end
    end

    assign cells[i] = cell_q;
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
  import mc16_pkg::*;
(
  input  fn_e   fn,
  input  word_t a,
  input  word_t b,
  output word_t y
);

  always_comb begin
    case (fn)
      FN_LTU:  y = (a < b) ? word_t'(1) : '0;
      FN_SUB:  y = a - b;
      FN_ADD:  y = a + b;
      FN_XOR:  y = a ^ b;
      FN_OR:   y = a | b;
      FN_AND:  y = a & b;
      FN_PASS: y = b;
      default: y = a;
    endcase
  end

endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
  import mc16_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  dec_t   dec,
  input  logic   opa_zero,
  output state_e state_q,
  output logic   ir_en,
  output logic   opr_en,
  output logic   mdr_en,
  output logic   rf_we,
  output logic   mem_we,
  output pcsel_e pc_sel,
  output wsel_e  wsel
);

  state_e state_d;
  logic   is_mem_op;

  assign is_mem_op = !dec.imm_form && ((dec.op == OP_LW) || (dec.op == OP_SW));

  always_comb begin
    state_d = state_q;
    ir_en   = 1'b0;
    opr_en  = 1'b0;
    mdr_en  = 1'b0;
    rf_we   = 1'b0;
    mem_we  = 1'b0;
    pc_sel  = PC_HOLD;
    wsel    = WB_ALU;
    case (state_q)
      ST_FETCH: begin
        ir_en   = 1'b1;
        pc_sel  = PC_INC;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        opr_en  = 1'b1;
        state_d = is_mem_op ? ST_MEM : ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_FETCH;
        if (dec.imm_form) begin
          rf_we = (dec.fn != FN_NONE);
        end else begin
          case (dec.op)
            OP_RALU: rf_we = (dec.fn != FN_NONE);
            OP_LUI: begin
              rf_we = 1'b1;
              wsel  = WB_UPPER;
            end
            OP_JL: begin
              rf_we  = 1'b1;
              wsel   = WB_LINK;
              pc_sel = PC_TARGET;
            end
            OP_JR:   pc_sel = PC_REG;
            OP_BNZ:  pc_sel = opa_zero ? PC_HOLD : PC_TARGET;
            OP_BZ:   pc_sel = opa_zero ? PC_TARGET : PC_HOLD;
            default: pc_sel = PC_HOLD;
          endcase
        end
      end
      ST_MEM: begin
        if (dec.op == OP_SW) begin
          mem_we  = 1'b1;
          state_d = ST_FETCH;
        end else begin
          mdr_en  = 1'b1;
          state_d = ST_WB;
        end
      end
      ST_WB: begin
        rf_we   = 1'b1;
        wsel    = WB_MEM;
        state_d = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter  int unsigned RST_STAGES = 2,
  localparam int unsigned DATA_W     = WORD_W,
  localparam int unsigned ADDR_W     = WORD_W
) (
  input  logic              clk,
  input  logic              arst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic   rst_sync_n;
  state_e state_q;
  logic   ir_en, opr_en, mdr_en, rf_we;
  pcsel_e pc_sel;
  wsel_e  wsel;

  word_t  ir_q, pc_q, opa_q, opb_q, tgt_q, mar_q, mdr_q;
  word_t  pc_d, rf_wdata, rd_a, rd_b, alu_b, alu_y;
  dec_t   dec;
  logic   opa_zero;

  mc16_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .srst_n (rst_sync_n)
  );

  assign dec      = decode(ir_q);
  assign opa_zero = (opa_q == '0);

  mc16_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .dec      (dec),
    .opa_zero (opa_zero),
    .state_q  (state_q),
    .ir_en    (ir_en),
    .opr_en   (opr_en),
    .mdr_en   (mdr_en),
    .rf_we    (rf_we),
    .mem_we   (mem_we),
    .pc_sel   (pc_sel),
    .wsel     (wsel)
  );

  mc16_regfile #(.W(WORD_W), .N(REG_CNT)) u_rf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (rf_we),
    .waddr   (dec.rd),
    .wdata   (rf_wdata),
    .raddr_a (dec.ra),
    .rdata_a (rd_a),
    .raddr_b (dec.rb),
    .rdata_b (rd_b)
  );

  assign alu_b = dec.imm_form ? sext9(ir_q[8:0]) : opb_q;

  mc16_alu u_alu (
    .fn (dec.fn),
    .a  (opa_q),
    .b  (alu_b),
    .y  (alu_y)
  );

  always_comb begin
    case (wsel)
      WB_UPPER: rf_wdata = upper(ir_q[7:0]);
      WB_LINK:  rf_wdata = pc_q;
      WB_MEM:   rf_wdata = mdr_q;
      default:  rf_wdata = alu_y;
    endcase
  end

  always_comb begin
    case (pc_sel)
      PC_INC:    pc_d = pc_q + word_t'(1);
      PC_TARGET: pc_d = tgt_q;
      PC_REG:    pc_d = opa_q;
      default:   pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q <= '0;
    end else if (pc_sel != PC_HOLD) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ir_q <= '0;
    end else if (ir_en) begin
      ir_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      opa_q <= '0;
      opb_q <= '0;
      tgt_q <= '0;
      mar_q <= '0;
    end else if (opr_en) begin
      opa_q <= rd_a;
      opb_q <= rd_b;
      tgt_q <= pc_q + sext9(ir_q[8:0]);
      mar_q <= rd_b + sext6(ir_q[5:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mdr_q <= '0;
    end else if (mdr_en) begin
      mdr_q <= mem_rdata;
    end
  end

  assign mem_addr  = (state_q == ST_MEM) ? mar_q : pc_q;
  assign mem_wdata = opa_q;

endmodule

// File: rtl/mc16_checker.sv
module mc16_checker
  import mc16_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input state_e state,
  input dec_t   dec,
  input word_t  pc,
  input word_t  opa,
  input word_t  mem_addr,
  input logic   mem_we,
  input logic   rf_we
);

  assert_we_only_in_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (state == ST_MEM));

  assert_load_takes_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MEM && !mem_we) |=> (state == ST_WB));

  assert_fetch_from_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH) |-> (mem_addr == pc));

  assert_fetch_steps_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH) |=> (pc == $past(pc) + word_t'(1)));

  assert_noop_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && dec.fn == FN_NONE && (dec.imm_form || dec.op == OP_RALU)) |-> !rf_we);

  assert_jr_loads_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && !dec.imm_form && dec.op == OP_JR) |=> (pc == $past(opa)));

  assert_branch_falls_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && !dec.imm_form &&
     ((dec.op == OP_BZ && opa != '0) || (dec.op == OP_BNZ && opa == '0)))
    |=> (pc == $past(pc)));

endmodule

bind mc16_core mc16_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .state    (state_q),
  .dec      (dec),
  .pc       (pc_q),
  .opa      (opa_q),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .rf_we    (rf_we)
);

// File: tb/sim_mc16_core.sv
`timescale 1ns/1ps
module sim_mc16_core;

  logic        clk = 1'b0;
  logic        arst_n;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;

  logic [15:0] mem  [0:1023];
  logic [15:0] prog [0:31];
  logic        ld_en;
  logic [9:0]  ld_addr;
  logic [15:0] ld_data;

  int total = 0;
  int fails = 0;
  int we_cnt;
  int we_cyc [0:3];

  logic [15:0] va [0:5] = '{16'h0000, 16'hFFFF, 16'h1234, 16'h8000, 16'h00FF, 16'hA5C3};
  logic [15:0] vb [0:5] = '{16'h0000, 16'h0001, 16'h5678, 16'h7FFF, 16'hFF00, 16'hA5C3};
  logic [8:0]  vi [0:5] = '{9'h000, 9'h0FF, 9'h100, 9'h1FF, 9'h07A, 9'h155};

  always #2.5 clk = ~clk;

  mc16_core u0 (
    .clk       (clk),
    .arst_n    (arst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[9:0]];

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
  end

  function automatic logic [15:0] e_r(logic [2:0] f, logic [2:0] s1, logic [2:0] s2, logic [2:0] d);
    return {4'b0000, s1, s2, d, f};
  endfunction
  function automatic logic [15:0] e_i(logic [2:0] f, logic [2:0] d, logic [8:0] imm);
    return {1'b1, f, d, imm};
  endfunction
  function automatic logic [15:0] e_lui(logic [2:0] r, logic [7:0] v);
    return {4'b0001, r, 1'b0, v};
  endfunction
  function automatic logic [15:0] e_lw(logic [2:0] r, logic [2:0] base, logic [5:0] off);
    return {4'b0010, r, base, off};
  endfunction
  function automatic logic [15:0] e_sw(logic [2:0] r, logic [2:0] base, logic [5:0] off);
    return {4'b0011, r, base, off};
  endfunction
  function automatic logic [15:0] e_jl(logic [2:0] r, logic [8:0] off);
    return {4'b0100, r, off};
  endfunction
  function automatic logic [15:0] e_jr(logic [2:0] r);
    return {4'b0101, r, 9'h000};
  endfunction
  function automatic logic [15:0] e_bnz(logic [2:0] r, logic [8:0] off);
    return {4'b0110, r, off};
  endfunction
  function automatic logic [15:0] e_bz(logic [2:0] r, logic [8:0] off);
    return {4'b0111, r, off};
  endfunction

  localparam logic [15:0] HALT = {4'b0100, 3'd0, 9'h1FF};

  function automatic logic [15:0] ref_alu(logic [2:0] f, logic [15:0] a, logic [15:0] b, logic [15:0] keep);
    case (f)
      3'd1:    return (a < b) ? 16'd1 : 16'd0;
      3'd2:    return a - b;
      3'd3:    return a + b;
      3'd4:    return a ^ b;
      3'd5:    return a | b;
      3'd6:    return a & b;
      3'd7:    return b;
      default: return keep;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) prog[i] = 16'h0000;
  endtask

  task automatic put_const(int at, logic [2:0] r, logic [15:0] v);
    prog[at]   = e_lui(r, v[15:8]);
    prog[at+1] = e_i(3'd5, r, {1'b0, v[7:0]});
  endtask

  task automatic run(int ncyc);
    arst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      ld_en   = 1'b1;
      ld_addr = 10'(i);
      ld_data = prog[i];
      @(negedge clk);
    end
    ld_en  = 1'b0;
    arst_n = 1'b1;
    we_cnt = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (mem_we) begin
        if (we_cnt < 4) we_cyc[we_cnt] = c;
        we_cnt++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    arst_n  = 1'b0;
    ld_en   = 1'b0;
    ld_addr = '0;
    ld_data = '0;
    repeat (3) @(negedge clk);
    // R1: idle bus while in reset
    check("R1 reset addr", mem_addr, 16'h0000);
    check("R1 reset we", {15'd0, mem_we}, 16'h0000);

    // R2 and R4: register ALU sweep, destination preset to a sentinel
    for (int p = 0; p < 6; p++) begin
      for (int f = 0; f < 8; f++) begin
        clear_prog();
        put_const(0, 3'd1, va[p]);
        put_const(2, 3'd2, vb[p]);
        put_const(4, 3'd3, 16'h5A5A);
        prog[6] = e_r(3'(f), 3'd1, 3'd2, 3'd3);
        prog[7] = e_sw(3'd3, 3'd0, 6'd16);
        prog[8] = HALT;
        run(45);
        check((f == 0) ? "R4 reg-form noop" : "R2 reg alu", mem[16],
              ref_alu(3'(f), va[p], vb[p], 16'h5A5A));
      end
    end

    // R2: destination equal to a source
    clear_prog();
    put_const(0, 3'd1, 16'h1234);
    put_const(2, 3'd2, 16'h5678);
    prog[4] = e_r(3'd3, 3'd1, 3'd2, 3'd1);
    prog[5] = e_r(3'd2, 3'd1, 3'd2, 3'd2);
    prog[6] = e_sw(3'd1, 3'd0, 6'd16);
    prog[7] = e_sw(3'd2, 3'd0, 6'd17);
    prog[8] = HALT;
    run(45);
    check("R2 dest=src1", mem[16], 16'h68AC);
    check("R2 dest=src2", mem[17], 16'h1234);

    // R3 and R4: immediate ALU sweep with sign-extended immediates
    for (int p = 0; p < 6; p++) begin
      for (int f = 0; f < 8; f++) begin
        clear_prog();
        put_const(0, 3'd1, va[p]);
        prog[2] = e_i(3'(f), 3'd1, vi[p]);
        prog[3] = e_sw(3'd1, 3'd0, 6'd16);
        prog[4] = HALT;
        run(30);
        check((f == 0) ? "R4 imm-form noop" : "R3 imm alu", mem[16],
              ref_alu(3'(f), va[p], {{7{vi[p][8]}}, vi[p]}, va[p]));
      end
    end

    // R5: upper immediate clears the low byte
    clear_prog();
    prog[0] = e_i(3'd7, 3'd4, 9'h0FF);
    prog[1] = e_lui(3'd4, 8'hC3);
    prog[2] = e_sw(3'd4, 3'd0, 6'd16);
    prog[3] = e_lui(3'd3, 8'h80);
    prog[4] = e_sw(3'd3, 3'd0, 6'd17);
    prog[5] = HALT;
    run(40);
    check("R5 lui over preset", mem[16], 16'hC300);
    check("R5 lui top bit", mem[17], 16'h8000);

    // R6: loads and stores with positive and negative offsets
    clear_prog();
    prog[20] = 16'hBEEF;
    prog[21] = 16'h1357;
    prog[0]  = e_i(3'd7, 3'd2, 9'd24);
    prog[1]  = e_lw(3'd3, 3'd2, 6'h3C);
    prog[2]  = e_sw(3'd3, 3'd2, 6'd5);
    prog[3]  = e_lw(3'd4, 3'd0, 6'd21);
    prog[4]  = e_sw(3'd4, 3'd2, 6'h3F);
    prog[5]  = HALT;
    run(45);
    check("R6 lw -4 then sw +5", mem[29], 16'hBEEF);
    check("R6 lw +21 then sw -1", mem[23], 16'h1357);

    // R7: forward and backward links; R1: untouched register is zero
    clear_prog();
    prog[0]  = e_jl(3'd6, 9'd3);
    prog[1]  = e_i(3'd7, 3'd1, 9'h055);
    prog[2]  = e_i(3'd7, 3'd1, 9'h055);
    prog[3]  = e_i(3'd7, 3'd1, 9'h055);
    prog[4]  = e_sw(3'd6, 3'd0, 6'd16);
    prog[5]  = e_sw(3'd1, 3'd0, 6'd17);
    prog[6]  = e_sw(3'd7, 3'd0, 6'd18);
    prog[7]  = e_jl(3'd5, 9'd3);
    prog[8]  = e_sw(3'd2, 3'd0, 6'd20);
    prog[9]  = HALT;
    prog[11] = e_sw(3'd5, 3'd0, 6'd19);
    prog[12] = e_jl(3'd2, 9'h1FB);
    run(60);
    check("R7 link value", mem[16], 16'd1);
    check("R7 skipped words", mem[17], 16'd0);
    check("R1 register cleared", mem[18], 16'd0);
    check("R7 second link", mem[19], 16'd8);
    check("R7 backward link", mem[20], 16'd13);

    // R8: register jump
    clear_prog();
    prog[0] = e_i(3'd7, 3'd2, 9'd6);
    prog[1] = e_jr(3'd2);
    prog[2] = e_i(3'd7, 3'd1, 9'd7);
    prog[6] = e_i(3'd7, 3'd1, 9'd9);
    prog[7] = e_sw(3'd1, 3'd0, 6'd16);
    prog[8] = HALT;
    run(40);
    check("R8 jr target", mem[16], 16'd9);

    // R9: all four taken/not-taken cases
    clear_prog();
    prog[0]  = e_i(3'd7, 3'd2, 9'd1);
    prog[1]  = e_bz(3'd0, 9'd1);
    prog[2]  = e_i(3'd7, 3'd3, 9'h011);
    prog[3]  = e_bnz(3'd0, 9'd1);
    prog[4]  = e_i(3'd7, 3'd4, 9'h022);
    prog[5]  = e_bnz(3'd2, 9'd1);
    prog[6]  = e_i(3'd7, 3'd5, 9'h033);
    prog[7]  = e_bz(3'd2, 9'd1);
    prog[8]  = e_i(3'd7, 3'd6, 9'h044);
    prog[9]  = e_sw(3'd3, 3'd0, 6'd16);
    prog[10] = e_sw(3'd4, 3'd0, 6'd17);
    prog[11] = e_sw(3'd5, 3'd0, 6'd18);
    prog[12] = e_sw(3'd6, 3'd0, 6'd19);
    prog[13] = HALT;
    run(70);
    check("R9 bz taken", mem[16], 16'h0000);
    check("R9 bnz not taken", mem[17], 16'h0022);
    check("R9 bnz taken", mem[18], 16'h0000);
    check("R9 bz not taken", mem[19], 16'h0044);

    // R10: gap between stores = add 3 + bz 3 + lw 4 + sw 3
    clear_prog();
    prog[0] = e_sw(3'd0, 3'd0, 6'd16);
    prog[1] = e_r(3'd3, 3'd1, 3'd1, 3'd1);
    prog[2] = e_bz(3'd1, 9'd0);
    prog[3] = e_lw(3'd2, 3'd0, 6'd16);
    prog[4] = e_sw(3'd2, 3'd0, 6'd17);
    prog[5] = HALT;
    run(50);
    check("R10 store strobes A", 16'(we_cnt), 16'd2);
    check("R10 gap A", 16'(we_cyc[1] - we_cyc[0]), 16'd13);

    // R10: gap = lw 4 + lw 4 + jl 3 + sw 3
    clear_prog();
    prog[16] = 16'h0777;
    prog[0] = e_sw(3'd0, 3'd0, 6'd17);
    prog[1] = e_lw(3'd1, 3'd0, 6'd16);
    prog[2] = e_lw(3'd2, 3'd0, 6'd16);
    prog[3] = e_jl(3'd3, 9'd0);
    prog[4] = e_sw(3'd2, 3'd0, 6'd18);
    prog[5] = HALT;
    run(50);
    check("R10 store strobes B", 16'(we_cnt), 16'd2);
    check("R10 gap B", 16'(we_cyc[1] - we_cyc[0]), 16'd14);
    check("R6 loaded data", mem[18], 16'h0777);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule